// File: doc/BRIEF.md
# DRAM Rank Refresh Scheduler

This block generates periodic refresh commands for one DRAM rank. A free-running interval timer raises a refresh request every fixed number of clock cycles. Requests that arrive while the command scheduler is busy are held in a small saturating backlog counter. A refresh command is sent once the scheduler reports idle and no earlier refresh is still running. Each command refreshes a group of rows in every bank in parallel. For the duration of that group's refresh, a busy flag holds off normal traffic. The busy time is the number of rows per bank in the group multiplied by the per-row refresh time.

A row pointer gives the base row of each command. After each command it advances by the group size and wraps at the number of rows per bank. The command count per retention window is therefore the rows per bank divided by the group size, and each row is refreshed once per sweep. The interval, group size, per-row time and rows per bank are parameters given in clock cycles. As a result, the fraction of time the rank is unavailable is fixed by the design: blocking cycles divided by interval cycles. With typical numbers (40 ns per row, 8 rows per bank, 7.8 us interval) this comes to about 4 %.

Top module: `dram_refresh_sched`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, ref_cmd_o and busy_o are 0 and ref_row_o is 0.
- R2: The interval timer raises one refresh request every IVL_CYC cycles, regardless of idle or busy state. Counting the first clock edge after reset as edge 1, requests are added at edges IVL_CYC, 2*IVL_CYC, and so on.
- R3: A command is issued at a clock edge only when a request is pending, sched_idle_i is high at that edge, and busy_o is low. ref_cmd_o is then high for exactly one cycle. With sched_idle_i held high, the first command appears after edge IVL_CYC+1.
- R4: busy_o rises in the same cycle as ref_cmd_o and stays high for exactly ROWS_PER_CMD*ROW_CYC cycles.
- R5: While ref_cmd_o is high, ref_row_o is the base row of that command. The base row starts at 0, advances by ROWS_PER_CMD after each command, wraps to 0 when it would reach ROWS_PER_BANK, and is otherwise unchanged.
- R6: The backlog of pending requests saturates at PEND_MAX. Requests that arrive while the backlog is full are dropped.
- R7: When requests remain pending and sched_idle_i is high, the next command follows the previous one after ROWS_PER_CMD*ROW_CYC+1 cycles, that is, at the first edge after busy_o falls.
- R8: When a new request arrives at the same edge that a command is issued, both are applied. The backlog is unchanged, and the carried request issues as soon as busy_o falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sched_idle_i | input | 1 | Command scheduler can give up the rank this cycle |
| ref_cmd_o | output | 1 | One-cycle refresh command pulse |
| ref_row_o | output | $clog2(ROWS_PER_BANK) | Base row of the current refresh group |
| busy_o | output | 1 | Rank blocked for refresh; normal traffic must hold |

## Verification
The timer's request increment and the issue-side decrement of the backlog can land on the same clock edge. The bench provokes this by holding the scheduler not-idle until exactly one request is pending. It then releases idle so that the first edge seeing idle is also a timer expiry edge. The check is judged at the ports: a command must appear at that edge, and a second command must follow at the first edge after busy falls. A lost or doubled request shows up as a missing command or an extra one.

// File: rtl/ref_pkg.sv
package ref_pkg;
  function automatic int unsigned blk_cycles(int unsigned rows, int unsigned row_cyc);
    return rows * row_cyc;
  endfunction
endpackage

// File: rtl/ref_ivl_timer.sv
module ref_ivl_timer #(
  parameter int unsigned IVL_CYC = 6240
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (IVL_CYC > 1) ? $clog2(IVL_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(IVL_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ref_busy_ctr.sv
module ref_busy_ctr #(
  parameter int unsigned BLK_CYC = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int unsigned BW = $clog2(BLK_CYC + 1);
  localparam logic [BW-1:0] LOADV = BW'(BLK_CYC);

  logic [BW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= LOADV;
    else if (busy_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/ref_row_ctr.sv
module ref_row_ctr #(
  parameter int unsigned ROWS_PER_BANK = 65536,
  parameter int unsigned ROW_STEP      = 8,
  localparam int unsigned RW = $clog2(ROWS_PER_BANK)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [RW-1:0] row_o
);
  logic [RW:0] sum;

  assign sum = {1'b0, row_o} + (RW+1)'(ROW_STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) row_o <= '0;
    else if (adv_i) begin
      if (sum >= (RW+1)'(ROWS_PER_BANK)) row_o <= '0;
      else                               row_o <= sum[RW-1:0];
    end
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import ref_pkg::*;
#(
  parameter int unsigned IVL_CYC       = 6240,
  parameter int unsigned ROWS_PER_BANK = 65536,
  parameter int unsigned ROWS_PER_CMD  = 8,
  parameter int unsigned ROW_CYC       = 32,
  parameter int unsigned PEND_MAX      = 8,
  localparam int unsigned RW = $clog2(ROWS_PER_BANK)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sched_idle_i,
  output logic          ref_cmd_o,
  output logic [RW-1:0] ref_row_o,
  output logic          busy_o
);
  localparam int unsigned BLK_CYC = blk_cycles(ROWS_PER_CMD, ROW_CYC);
  localparam int unsigned PW = $clog2(PEND_MAX + 1);
  localparam logic [PW-1:0] PMAX = PW'(PEND_MAX);

  logic          tick;
  logic          issue;
  logic [PW-1:0] pend_q;
  logic [PW-1:0] pend_d;

  ref_ivl_timer #(.IVL_CYC(IVL_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  ref_busy_ctr #(.BLK_CYC(BLK_CYC)) u_busy (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(issue),
    .busy_o(busy_o)
  );

  ref_row_ctr #(.ROWS_PER_BANK(ROWS_PER_BANK), .ROW_STEP(ROWS_PER_CMD)) u_row (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (ref_cmd_o),
    .row_o (ref_row_o)
  );

  assign issue = (pend_q != '0) && sched_idle_i && !busy_o;

  always_comb begin
    pend_d = pend_q;
    unique case ({tick, issue})
      2'b10:   if (pend_q != PMAX) pend_d = pend_q + 1'b1;
      2'b01:   pend_d = pend_q - 1'b1;
      default: pend_d = pend_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= '0;
      ref_cmd_o <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      ref_cmd_o <= issue;
    end
  end
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int unsigned ROWS_PER_BANK = 65536,
  parameter int unsigned ROWS_PER_CMD  = 8,
  parameter int unsigned ROW_CYC       = 32,
  parameter int unsigned PEND_MAX      = 8,
  parameter int unsigned RW            = 16,
  parameter int unsigned PW            = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sched_idle_i,
  input logic          ref_cmd_o,
  input logic [RW-1:0] ref_row_o,
  input logic          busy_o,
  input logic [PW-1:0] pend_q
);
  localparam int unsigned BLK = ROWS_PER_CMD * ROW_CYC;

  int unsigned blen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        blen_q <= 0;
    else if (ref_cmd_o) blen_q <= 1;
    else if (busy_o)    blen_q <= blen_q + 1;
  end

  // R3
  cmd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cmd_o |=> !ref_cmd_o);
  // R3
  cmd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cmd_o |-> $past(sched_idle_i) && !$past(busy_o));
  // R4
  cmd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cmd_o |-> busy_o);
  // R4
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> blen_q == BLK);
  // R5
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ref_cmd_o) |-> $stable(ref_row_o));
  // R5
  row_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cmd_o |-> (32'(ref_row_o) % ROWS_PER_CMD == 0) && (32'(ref_row_o) < ROWS_PER_BANK));
  // R6
  pend_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(pend_q) <= PEND_MAX);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .ROWS_PER_BANK(ROWS_PER_BANK),
  .ROWS_PER_CMD (ROWS_PER_CMD),
  .ROW_CYC      (ROW_CYC),
  .PEND_MAX     (PEND_MAX),
  .RW           (RW),
  .PW           (PW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sched_idle_i(sched_idle_i),
  .ref_cmd_o   (ref_cmd_o),
  .ref_row_o   (ref_row_o),
  .busy_o      (busy_o),
  .pend_q      (pend_q)
);

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IVL   = 20;
  localparam int RPB   = 8;
  localparam int STEP  = 2;
  localparam int RCYC  = 3;
  localparam int PMAX  = 2;
  localparam int BLK   = STEP * RCYC;
  localparam int RW    = $clog2(RPB);
  localparam int LAST  = 275;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle = 1'b1;
  logic cmd;
  logic busy;
  logic [RW-1:0] row;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_refresh_sched #(
    .IVL_CYC(IVL), .ROWS_PER_BANK(RPB), .ROWS_PER_CMD(STEP),
    .ROW_CYC(RCYC), .PEND_MAX(PMAX)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sched_idle_i(idle),
    .ref_cmd_o(cmd), .ref_row_o(row), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // idle level seen at edge k
  function automatic bit idle_at(input int k);
    return !((k >= 111 && k <= 181) || (k >= 211 && k <= 239));
  endfunction

  function automatic bit exp_cmd(input int k);
    if (k >= 21 && k <= 110 && k % IVL == 1) return 1'b1;
    return (k == 182 || k == 189 || k == 201 || k == 240 || k == 247 || k == 261);
  endfunction

  function automatic string req_of(input int k);
    if (k <= 110) return "R2";
    if (k <= 181 || (k >= 211 && k <= 239)) return "R3";
    if (k <= 200) return "R7";
    if (k >= 240 && k <= 247) return "R8";
    return "R6";
  endfunction

  initial begin
    int last_cmd;
    int nth;
    int cnt_b;
    last_cmd = -1000;
    nth = 0;
    cnt_b = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(cmd == 1'b0, "R1", cmd, 0);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(row == '0, "R1", row, 0);
    rst_n = 1'b1;
    idle = idle_at(1);
    for (int k = 1; k <= LAST; k++) begin
      @(posedge clk);
      cyc = k;
      @(negedge clk);
      if (k == 1) begin
        chk(cmd == 1'b0 && busy == 1'b0 && row == '0, "R1", {cmd, busy}, 0);
      end
      chk(cmd == exp_cmd(k), req_of(k), cmd, exp_cmd(k));
      if (exp_cmd(k)) begin
        chk(int'(row) == (nth * STEP) % RPB, "R5", row, (nth * STEP) % RPB);
        nth++;
        last_cmd = k;
        if (k >= 182 && k <= 200) cnt_b++;
      end
      chk(busy == ((k - last_cmd) < BLK), "R4", busy, (k - last_cmd) < BLK);
      idle = idle_at(k + 1);
    end
    // R6: backlog of PMAX drained back to back, extra requests dropped
    chk(cnt_b == PMAX, "R6", cnt_b, PMAX);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule